// File: doc/BRIEF.md
# Serial Audio Receive Lane

This block receives one stereo lane of a three-wire serial audio link on which an external master drives the bit clock and the word-select line. All three lines are sampled with a much faster system clock. The bit clock can be passed through a debounce filter. A small state machine locks onto the word-select transitions, collects the bits of each channel slot most significant bit first, and turns every finished slot into a 32-bit word. The words go into an eight-entry FIFO that the consumer drains through a show-ahead read port.

A single control word selects how the lane behaves:
- one-bit-delayed (I2S) or left-justified framing;
- which bit-clock edge samples the data;
- which word-select level marks the left channel;
- the output packing: a two-sample 16-bit pair, a 24-bit right-aligned sample, or a full 32-bit sample;
- the filter strength, chosen from the ratio of system clock to bit clock.

Software disables the lane, rewrites the format, and enables it again. Pulsing the flush bit clears the FIFO.

The deserializer state machine has four states:
- `ST_IDLE`: the lane is disabled.
- `ST_HUNT`: the lane is enabled and waits for the start of a left slot.
- `ST_SHIFT`: bits of a slot are being collected.
- `ST_HOLD`: the slot is complete and the lane waits for the next word-select start.

Its transitions are:
- IDLE→HUNT when the enable bit is set.
- HUNT→SHIFT on a left-slot start.
- SHIFT→HOLD on the last bit of a slot.
- HOLD→SHIFT on any slot start.
- SHIFT→SHIFT on a slot start that arrives early. The partial slot is discarded.
- Any state→IDLE when the enable bit is cleared. This also drops a held left half.

Top module: `i2s_rx_lane`

## Requirements
- R1: After reset `ctrl_q` reads 0x00020404, which is delay field 4 in bits [17:15], bit 10 set and bit 2 set. `rd_valid` is 0, `fifo_level` is 0 and `overflow` is 0.
- R2: A control write keeps only bits 0-3, 6-10 and 12-17. All other bits read back as 0, so writing all ones reads back 0x0003F7CF.
- R3: With bit 12 = 0 and bit 9 = 1 (full-width mode), each 32-bit slot is emitted as one word holding the whole sample. The left word comes before the right word.
- R4: With bit 8 = 1, the first (MSB) bit of a slot is the one sampled one bit-clock after the word-select change. With bit 8 = 0, it is the bit sampled on the same edge as the change.
- R5: With bit 12 = 0 and bit 9 = 0, the word is the top 24 bits of the 32-bit slot, right-aligned and sign-extended from slot bit 31.
- R6: With bit 12 = 1, slots are 16 bits. One word `{left[15:0], right[15:0]}` is emitted per left/right pair.
- R7: With bit 7 = 0, data is sampled on rising bit-clock edges. With bit 7 = 1, data is sampled on falling edges.
- R8: With bit 3 = 0, word-select high marks the left slot. With bit 3 = 1, word-select low marks the left slot.
- R9: While bit 0 (enable) is 0, no word enters the FIFO. After enabling, the first emitted word belongs to a left slot.
- R10: With bit 14 = 1, a bit-clock level change must persist for 3 system clocks (bit 13 = 0) or 2 system clocks (bit 13 = 1) before it counts. Shorter pulses have no effect on the received data.
- R11: The FIFO holds 8 words. A word that arrives while the FIFO is full is dropped, the stored words are kept, and the sticky `overflow` output rises.
- R12: Setting bit 6 and then clearing it leaves the FIFO empty and clears `overflow`. Words that arrive while bit 6 is set are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 6x the bit-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word to write |
| ctrl_q | output | 32 | Current control word |
| sck_in | input | 1 | Serial bit clock from the master |
| ws_in | input | 1 | Word-select from the master |
| sd_in | input | 1 | Serial data |
| rd_en | input | 1 | Pop the head word of the FIFO |
| rd_data | output | DW | Head word of the FIFO (show-ahead) |
| rd_valid | output | 1 | FIFO is not empty |
| fifo_level | output | clog2(FIFO_DEPTH+1) | Number of stored words |
| overflow | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
A wrong slot counter or a wrong framing choice shifts every later bit. The first word out is then a rotated or half-swapped copy of the driven value, which shows on `rd_data` about one slot time (16 or 32 bit clocks) after the fault. A state machine stuck in HUNT or IDLE gives an empty FIFO. A lost left half in packed mode gives a missing or misordered pair. Both show up when the scoreboard finds its queue of expected words still populated after the burst ends. Filter or FIFO-pointer faults show up as extra words, corrupted words, or a wrong `fifo_level` and `overflow` within a few system clocks of the stimulus.

// File: rtl/i2s_rx_pkg.sv
`timescale 1ns/1ps
package i2s_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SHIFT,
        ST_HOLD
    } rx_state_e;

    // Control word bit positions
    localparam int unsigned CB_EN     = 0;
    localparam int unsigned CB_LRPOL  = 3;
    localparam int unsigned CB_FLUSH  = 6;
    localparam int unsigned CB_CKPOL  = 7;
    localparam int unsigned CB_DLY1   = 8;
    localparam int unsigned CB_PACKH  = 9;
    localparam int unsigned CB_PK16   = 12;
    localparam int unsigned CB_FMODE  = 13;
    localparam int unsigned CB_FEN    = 14;

    localparam logic [31:0] CTRL_MASK  = 32'h0003_F7CF;
    localparam logic [31:0] CTRL_RESET = 32'h0002_0404;

    typedef struct packed {
        logic en;
        logic lrpol;
        logic flush;
        logic ckpol;
        logic dly1;
        logic packh;
        logic pk16;
        logic fmode;
        logic fen;
    } rx_cfg_t;

endpackage

// File: rtl/i2s_rx_edge.sv
`timescale 1ns/1ps
module i2s_rx_edge #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LONG   = 3,
    parameter int FILT_SHORT  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fen,
    input  logic fmode,
    input  logic ckpol,
    input  logic sck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic samp,
    output logic ws_s,
    output logic sd_s
);
    localparam int CW = $clog2(FILT_LONG + 1);

    logic [SYNC_STAGES-1:0] sck_sr, ws_sr, sd_sr;
    logic                   sck_s;
    logic                   filt_q, filt_prev_q;
    logic [CW-1:0]          run_q;
    logic [CW-1:0]          need_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sr <= '0;
            ws_sr  <= '0;
            sd_sr  <= '0;
        end else begin
            sck_sr <= {sck_sr[SYNC_STAGES-2:0], sck_in};
            ws_sr  <= {ws_sr[SYNC_STAGES-2:0], ws_in};
            sd_sr  <= {sd_sr[SYNC_STAGES-2:0], sd_in};
        end
    end

    assign sck_s  = sck_sr[SYNC_STAGES-1];
    assign ws_s   = ws_sr[SYNC_STAGES-1];
    assign sd_s   = sd_sr[SYNC_STAGES-1];
    assign need_c = fmode ? CW'(FILT_SHORT - 1) : CW'(FILT_LONG - 1);

    // Debounce: a new level is taken once it has persisted for the required run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q      <= 1'b0;
            filt_prev_q <= 1'b0;
            run_q       <= '0;
        end else begin
            filt_prev_q <= filt_q;
            if (!fen) begin
                filt_q <= sck_s;
                run_q  <= '0;
            end else if (sck_s != filt_q) begin
                if (run_q == need_c) begin
                    filt_q <= sck_s;
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign samp = (filt_q != filt_prev_q) && (filt_q == ~ckpol);

    // R10: with the filter on, two accepted level changes are never back to back
    p_filter_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fen && (filt_q != filt_prev_q)) |=> $stable(filt_q));

endmodule

// File: rtl/i2s_rx_deser.sv
`timescale 1ns/1ps
module i2s_rx_deser
    import i2s_rx_pkg::*;
#(
    parameter int DW       = 32,
    parameter int SAMPLE_W = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dly1,
    input  logic          lrpol,
    input  logic          packh,
    input  logic          pk16,
    input  logic          samp,
    input  logic          ws_s,
    input  logic          sd_s,
    output logic          wr_valid,
    output logic [DW-1:0] wr_data
);
    localparam int CNTW = $clog2(DW + 1);
    localparam int HALF = DW / 2;
    localparam int PAD  = DW - SAMPLE_W;

    rx_state_e         state_q, state_d;
    logic              ws_d_q, chg_d_q;
    logic [DW-1:0]     shreg_q, shifted;
    logic [CNTW-1:0]   cnt_q, slot;
    logic              cur_left_q;
    logic [HALF-1:0]   left_hold_q;
    logic              left_ok_q;
    logic              lr, chg, start, start_left, load, last_bit;

    assign lr         = ws_s ^ lrpol;
    assign chg        = lr != ws_d_q;
    assign start      = dly1 ? chg_d_q : chg;
    assign start_left = dly1 ? ws_d_q : lr;
    assign slot       = pk16 ? CNTW'(HALF) : CNTW'(DW);
    assign shifted    = {shreg_q[DW-2:0], sd_s};
    assign last_bit   = (state_q == ST_SHIFT) && samp && !start && ((cnt_q + 1'b1) == slot);
    assign load       = en && samp && start &&
                        ((state_q == ST_SHIFT) || (state_q == ST_HOLD) ||
                         ((state_q == ST_HUNT) && start_left));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en) state_d = ST_HUNT;
            ST_HUNT:  if (samp && start && start_left) state_d = ST_SHIFT;
            ST_SHIFT: if (last_bit) state_d = ST_HOLD;
            ST_HOLD:  if (samp && start) state_d = ST_SHIFT;
        endcase
        if (!en) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_d_q      <= 1'b0;
            chg_d_q     <= 1'b0;
            shreg_q     <= '0;
            cnt_q       <= '0;
            cur_left_q  <= 1'b0;
            left_hold_q <= '0;
            left_ok_q   <= 1'b0;
            wr_valid    <= 1'b0;
            wr_data     <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (samp) begin
                ws_d_q  <= lr;
                chg_d_q <= chg;
            end
            if (load) begin
                shreg_q    <= {{(DW-1){1'b0}}, sd_s};
                cnt_q      <= CNTW'(1);
                cur_left_q <= start_left;
            end else if ((state_q == ST_SHIFT) && samp) begin
                shreg_q <= shifted;
                cnt_q   <= cnt_q + 1'b1;
            end
            if (last_bit && en) begin
                if (pk16) begin
                    if (cur_left_q) begin
                        left_hold_q <= shifted[HALF-1:0];
                        left_ok_q   <= 1'b1;
                    end else if (left_ok_q) begin
                        wr_valid  <= 1'b1;
                        wr_data   <= {left_hold_q, shifted[HALF-1:0]};
                        left_ok_q <= 1'b0;
                    end
                end else begin
                    wr_valid <= 1'b1;
                    wr_data  <= packh ? shifted : {{PAD{shifted[DW-1]}}, shifted[DW-1:PAD]};
                end
            end
            if (state_q == ST_IDLE) left_ok_q <= 1'b0;
        end
    end

    // R3: the bit count never runs past a full slot
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(DW));
    // R3: a word is only produced out of the collecting state
    p_emit_from_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(state_q) == ST_SHIFT));
    // R9: a disabled lane produces nothing on the following cycle
    p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !wr_valid);

endmodule

// File: rtl/i2s_rx_fifo.sv
`timescale 1ns/1ps
module i2s_rx_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic          ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic          full, push_ok, pop_ok;

    assign full    = (level == LW'(DEPTH));
    assign push_ok = wr_valid && !flush && !full;
    assign pop_ok  = rd_en && (level != '0) && !flush;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            level <= level + LW'(push_ok) - LW'(pop_ok);
            if (wr_valid && full) ovf <= 1'b1;
        end
    end

    assign rd_data  = mem[rptr_q];
    assign rd_valid = (level != '0);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !flush && !rd_en) |=> ((level == LW'(DEPTH)) && ovf));
    p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush) |-> ((level == '0) && !ovf));

endmodule

// File: rtl/i2s_rx_lane.sv
`timescale 1ns/1ps
module i2s_rx_lane
    import i2s_rx_pkg::*;
#(
    parameter int DW          = 32,
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LONG   = 3,
    parameter int FILT_SHORT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [31:0]   ctrl_wdata,
    output logic [31:0]   ctrl_q,
    input  logic          sck_in,
    input  logic          ws_in,
    input  logic          sd_in,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
    output logic          overflow
);
    rx_cfg_t       cfg;
    logic          samp, ws_s, sd_s;
    logic          wr_valid;
    logic [DW-1:0] wr_data;
    logic [7:0]    unused_ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (ctrl_wr) ctrl_q <= ctrl_wdata & CTRL_MASK;
    end

    assign cfg.en    = ctrl_q[CB_EN];
    assign cfg.lrpol = ctrl_q[CB_LRPOL];
    assign cfg.flush = ctrl_q[CB_FLUSH];
    assign cfg.ckpol = ctrl_q[CB_CKPOL];
    assign cfg.dly1  = ctrl_q[CB_DLY1];
    assign cfg.packh = ctrl_q[CB_PACKH];
    assign cfg.pk16  = ctrl_q[CB_PK16];
    assign cfg.fmode = ctrl_q[CB_FMODE];
    assign cfg.fen   = ctrl_q[CB_FEN];
    assign unused_ctrl = {ctrl_q[17:15], ctrl_q[10], ctrl_q[2:1], ctrl_q[11], ctrl_q[5]};

    i2s_rx_edge #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LONG   (FILT_LONG),
        .FILT_SHORT  (FILT_SHORT)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .fen    (cfg.fen),
        .fmode  (cfg.fmode),
        .ckpol  (cfg.ckpol),
        .sck_in (sck_in),
        .ws_in  (ws_in),
        .sd_in  (sd_in),
        .samp   (samp),
        .ws_s   (ws_s),
        .sd_s   (sd_s)
    );

    i2s_rx_deser #(
        .DW (DW)
    ) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.en),
        .dly1     (cfg.dly1),
        .lrpol    (cfg.lrpol),
        .packh    (cfg.packh),
        .pk16     (cfg.pk16),
        .samp     (samp),
        .ws_s     (ws_s),
        .sd_s     (sd_s),
        .wr_valid (wr_valid),
        .wr_data  (wr_data)
    );

    i2s_rx_fifo #(
        .DW    (DW),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cfg.flush),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .level    (fifo_level),
        .ovf      (overflow)
    );

    // R2: undefined control bits never hold a one
    p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_wr) |-> ((ctrl_q & ~CTRL_MASK) == 32'h0));

endmodule

// File: tb/i2s_rx_lane_bench.sv
`timescale 1ns/1ps
module i2s_rx_lane_bench;
    localparam int H = 8; // system clocks per bit-clock half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] ctrl_q;
    logic        c = 1'b1;
    logic        inv = 1'b0;
    logic        sck_in;
    logic        ws_in = 1'b0;
    logic        sd_in = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [3:0]  fifo_level;
    logic        overflow;

    int checks = 0;
    int failures = 0;
    int exp_budget = 1000000;
    bit mon_en = 1'b1;
    string cur_req = "R3";
    logic [31:0] exp_q[$];

    // format selection used by the driver
    int W = 32;
    bit dly = 0, lrpol = 0, pk16 = 0, packh = 1, ckpol = 0, fen = 0, fmode = 0;
    int glitch = 0;

    assign sck_in = c ^ inv;

    always #4 clk = ~clk;

    i2s_rx_lane u_i2s_rx_lane (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .fifo_level(fifo_level), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_word(input bit en, input bit flush);
        return {14'd0, 3'd4, fen, fmode, pk16, 1'b0, 1'b1, packh, dly, ckpol,
                flush, 2'b00, lrpol, 1'b1, 1'b0, en};
    endfunction

    function automatic logic [31:0] fmt(input logic [31:0] x);
        return packh ? x : {{8{x[31]}}, x[31:8]};
    endfunction

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic configure();
        wr_ctrl(cfg_word(0, 0));
        inv = ckpol;
        repeat (4) @(negedge clk);
        wr_ctrl(cfg_word(1, 0));
    endtask

    task automatic push_exp(input logic [31:0] v);
        if (exp_budget > 0) begin
            exp_q.push_back(v);
            exp_budget--;
        end
    endtask

    task automatic send_bit(input bit w, input bit d);
        c = 1'b0;
        ws_in = w;
        sd_in = d;
        if (glitch > 0) begin
            repeat (2) @(negedge clk);
            c = 1'b1;
            repeat (glitch) @(negedge clk);
            c = 1'b0;
            repeat (H - 2 - glitch) @(negedge clk);
        end else begin
            repeat (H) @(negedge clk);
        end
        c = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
        bit lvl;
        lvl = lrpol ? 1'b0 : 1'b1;
        if (pk16) push_exp({l[15:0], r[15:0]});
        else begin
            push_exp(fmt(l));
            push_exp(fmt(r));
        end
        for (int k = 0; k < 2 * W; k++) begin
            int kk;
            bit w, d;
            kk = dly ? (k + 1) % (2 * W) : k;
            w = (kk < W) ? lvl : ~lvl;
            d = (k < W) ? l[W-1-k] : r[2*W-1-k];
            send_bit(w, d);
        end
    endtask

    task automatic run_burst(input int n, input logic [31:0] seed);
        bit lvl;
        lvl = lrpol ? 1'b0 : 1'b1;
        @(negedge clk);
        send_bit(~lvl, 1'b0);
        send_bit(dly ? lvl : ~lvl, 1'b0);
        for (int i = 0; i < n; i++) begin
            logic [31:0] l, r;
            l = seed ^ (32'h1357_9BDF * (i + 1));
            r = {l[15:0], ~l[31:16]};
            send_frame(l, r);
        end
    endtask

    task automatic settle(input string req);
        repeat (120) @(negedge clk);
        chk(req, exp_q.size(), 0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rd_valid && rst_n) begin
                if (exp_q.size() == 0) begin
                    chk(cur_req, rd_data, 32'hxxxx_xxxx);
                end else begin
                    chk(cur_req, rd_data, exp_q.pop_front());
                end
                rd_en = 1'b1;
            end else begin
                rd_en = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", ctrl_q, 32'h0002_0404);
        chk("R1", {31'd0, rd_valid}, 0);
        chk("R1", {28'd0, fifo_level}, 0);
        chk("R1", {31'd0, overflow}, 0);

        wr_ctrl(32'hFFFF_FFFF);
        chk("R2", ctrl_q, 32'h0003_F7CF);
        wr_ctrl(32'h0000_0000);
        chk("R2", ctrl_q, 32'h0000_0000);

        // R9: disabled lane stores nothing
        cur_req = "R9";
        wr_ctrl(cfg_word(0, 0));
        exp_budget = 0;
        run_burst(2, 32'h1111_2222);
        repeat (60) @(negedge clk);
        chk("R9", {28'd0, fifo_level}, 0);
        exp_budget = 1000000;

        // R3: left-justified, full 32-bit words, ws high = left
        cur_req = "R3"; W = 32; dly = 0; lrpol = 0; pk16 = 0; packh = 1;
        configure(); run_burst(3, 32'hDEAD_BEEF); settle("R3");

        // R4 + R8: one-bit delayed framing, ws low = left
        cur_req = "R4"; dly = 1; lrpol = 1;
        configure(); run_burst(3, 32'h8421_7E5A); settle("R4");

        // R5: 24-bit right-aligned sign-extended
        cur_req = "R5"; packh = 0;
        configure(); run_burst(3, 32'hF0F0_1234); settle("R5");

        // R6: 16-bit pairs, left-justified
        cur_req = "R6"; W = 16; pk16 = 1; dly = 0; lrpol = 0;
        configure(); run_burst(3, 32'h0000_C3A5); settle("R6");

        // R7: falling-edge sampling
        cur_req = "R7"; W = 32; pk16 = 0; packh = 1; dly = 1; ckpol = 1;
        configure(); run_burst(2, 32'h5A5A_0FF0); settle("R7");

        // R8: ws low = left with left-justified framing
        cur_req = "R8"; ckpol = 0; dly = 0; lrpol = 1;
        configure(); run_burst(2, 32'h7654_3210); settle("R8");

        // R10: filter rejects short bit-clock pulses
        cur_req = "R10"; lrpol = 0; fen = 1; fmode = 0; glitch = 2;
        configure(); run_burst(2, 32'hACE1_0BAD); settle("R10");
        fmode = 1; glitch = 1;
        configure(); run_burst(2, 32'h3C3C_9669); settle("R10");
        fen = 0; fmode = 0; glitch = 0;

        // R11: overflow drops new words, keeps stored ones
        cur_req = "R11";
        configure();
        mon_en = 1'b0;
        exp_budget = 8;
        run_burst(5, 32'h0BAD_F00D);
        repeat (60) @(negedge clk);
        chk("R11", {28'd0, fifo_level}, 8);
        chk("R11", {31'd0, overflow}, 1);
        exp_budget = 1000000;
        mon_en = 1'b1;
        settle("R11");
        chk("R11", {31'd0, overflow}, 1);

        // R12: flush empties FIFO and clears overflow
        cur_req = "R12";
        mon_en = 1'b0;
        run_burst(2, 32'h2468_ACE0);
        repeat (60) @(negedge clk);
        chk("R12", {28'd0, fifo_level}, 4);
        wr_ctrl(cfg_word(1, 1));
        wr_ctrl(cfg_word(1, 0));
        @(negedge clk);
        chk("R12", {28'd0, fifo_level}, 0);
        chk("R12", {31'd0, overflow}, 0);
        chk("R12", {31'd0, rd_valid}, 0);
        exp_q.delete();
        mon_en = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule